// File: doc/BRIEF.md
# Shared-Bus TDM Serial Transmitter

This block is the sending side of a serial port that lets several processors share one pair of serial lines with no glue logic between them. Time on the lines is split into frames of eight slots, each sixteen bit-clocks long. Each node has a mask of the slots it owns. In an owned slot it drives a 16-bit data word on the data lane. At the same time it drives a second lane: first an 8-bit destination address, in which each bit selects one group of receivers, then an 8-bit protocol byte. In every slot it does not own, both lanes are released.

The block runs on the bit clock. A free-running position counter divides the frame into slots and bit times. A node that owns slot 0 is the frame master: it produces the frame sync itself and ignores the sync input. Every other node restarts its counter on the incoming sync pulse. Software loads four values with a simple write port: the slot mask, the destination address, the protocol byte and the data word. All lane outputs are registered, so the bit for frame position p appears one bit clock after the counter reaches p. Slave receivers therefore see slot 0, bit 0 in the clock after the sync pulse.

Top module: `tdm_mp_tx`

## Requirements
- R1: While `rst` is high and after it falls, with no writes, `dat_oe`, `ap_oe`, `fsync_oe`, `fsync_out` and `tx_done` are low, because every register clears to zero.
- R2: A frame is 128 positions: slot = position/16 and bit = position%16. In slave mode, the clock in which `fsync_in` is high is counted as position 0, whatever the count was before. Outputs for position p are visible in the following clock.
- R3: Bit k of the slot mask enables transmission in slot k. Any number of bits may be set, and the node then drives every enabled slot.
- R4: In an owned slot the data lane carries the data word most significant bit first, one bit per clock, over 16 clocks.
- R5: In an owned slot the address lane carries the destination address, bit 7 first, during bits 0..7. It then carries the protocol byte, bit 7 first, during bits 8..15.
- R6: A protocol write keeps only `wr_data[7:0]`. The upper byte has no effect on the address lane.
- R7: In a slot not enabled in the mask, `dat_oe` and `ap_oe` are both low for all 16 bit times.
- R8: When mask bit 0 is set, `fsync_oe` is high. `fsync_out` is a one-clock pulse every 128 clocks, in the same clock as slot 0 bit 0 on the lanes. `fsync_in` is ignored.
- R9: The data word and protocol byte are captured at bit 0 of each owned slot. A write during a slot takes effect from the next owned slot.
- R10: `tx_done` pulses for one clock, in the same clock as bit 15 of each owned slot, and never in an unowned slot.
- R11: Write select `wr_sel` encodes the target register: 0 loads the slot mask from `wr_data[7:0]`, 1 the destination address from `wr_data[7:0]`, 2 the protocol byte, and 3 the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Frame sync from the bus (slave mode) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (R11) |
| wr_data | input | 16 | Write value |
| dat_o | output | 1 | Data lane bit |
| dat_oe | output | 1 | Data lane output enable |
| ap_o | output | 1 | Address/protocol lane bit |
| ap_oe | output | 1 | Address/protocol lane output enable |
| fsync_out | output | 1 | Generated frame sync (master) |
| fsync_oe | output | 1 | Frame sync output enable |
| tx_done | output | 1 | Slot transmission complete strobe |

## Verification
The hardest case to reach is a register write that lands inside a slot the node is already sending. The word on the lanes must stay the old one, and the next owned slot must carry the new one. The stimulus gets there by starting a slave frame with the sync pulse and counting bit clocks from it. It issues the data write at bit 4 of slot 1 while slots 1 and 2 are owned, then reassembles both slots from the lanes. A second hard case is a stray sync pulse reaching a master node in the middle of a frame. The bench drives one at position 40 and checks that the generated sync keeps its 128-clock period.

// File: rtl/tdm_mp_pkg.sv
package tdm_mp_pkg;
  parameter int unsigned SLOTS_DEF     = 8;
  parameter int unsigned SLOT_BITS_DEF = 16;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_TADDR = 2'd1,
    SEL_PROTO = 2'd2,
    SEL_DATA  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
  import tdm_mp_pkg::*;
#(
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned WORD_W = SLOT_BITS_DEF,
  parameter int unsigned HALF_W = SLOT_BITS_DEF / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [SLOTS-1:0]  slot_mask,
  output logic [HALF_W-1:0] tx_addr,
  output logic [HALF_W-1:0] proto,
  output logic [WORD_W-1:0] data_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_mask <= '0;
      tx_addr   <= '0;
      proto     <= '0;
      data_word <= '0;
    end else if (wr_en) begin
      case (wr_sel_e'(wr_sel))
        SEL_MASK:  slot_mask <= wr_data[SLOTS-1:0];
        SEL_TADDR: tx_addr   <= wr_data[HALF_W-1:0];
        SEL_PROTO: proto     <= wr_data[HALF_W-1:0];
        default:   data_word <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_mp_pkg::*;
#(
  parameter int unsigned SLOTS     = SLOTS_DEF,
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  localparam int unsigned SW       = $clog2(SLOTS),
  localparam int unsigned BW       = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          follow_ext,
  input  logic          fsync_in,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx,
  output logic          frame_start
);
  localparam int unsigned POS_W = SW + BW;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS * SLOT_BITS - 1);

  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] pos;

  always_comb begin
    pos = (follow_ext && fsync_in) ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
  end

  assign slot_idx    = pos[POS_W-1:BW];
  assign bit_idx     = pos[BW-1:0];
  assign frame_start = (pos == '0);
endmodule

// File: rtl/tdm_lane_shifter.sv
module tdm_lane_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         active,
  input  logic [W-1:0] par_in,
  output logic         bit_o,
  output logic         oe_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      oe_o <= active;
      if (load) begin
        bit_o <= par_in[W-1];
        sh_q  <= {par_in[W-2:0], 1'b0};
      end else begin
        bit_o <= active ? sh_q[W-1] : 1'b0;
        sh_q  <= {sh_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/tdm_mp_tx.sv
module tdm_mp_tx
  import tdm_mp_pkg::*;
#(
  parameter int unsigned SLOTS     = SLOTS_DEF,
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync_in,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [SLOT_BITS-1:0] wr_data,
  output logic                 dat_o,
  output logic                 dat_oe,
  output logic                 ap_o,
  output logic                 ap_oe,
  output logic                 fsync_out,
  output logic                 fsync_oe,
  output logic                 tx_done
);
  localparam int unsigned SW     = $clog2(SLOTS);
  localparam int unsigned BW     = $clog2(SLOT_BITS);
  localparam int unsigned HALF_W = SLOT_BITS / 2;
  localparam int unsigned LANES  = 2;
  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);

  logic [SLOTS-1:0]     slot_mask;
  logic [HALF_W-1:0]    tx_addr;
  logic [HALF_W-1:0]    proto;
  logic [SLOT_BITS-1:0] data_word;
  logic [SW-1:0]        slot_idx;
  logic [BW-1:0]        bit_idx;
  logic                 frame_start;
  logic                 master;
  logic                 own_q;
  logic                 own_now;
  logic                 slot_load;

  tdm_cfg_regs #(.SLOTS(SLOTS), .WORD_W(SLOT_BITS), .HALF_W(HALF_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .slot_mask (slot_mask),
    .tx_addr   (tx_addr),
    .proto     (proto),
    .data_word (data_word)
  );

  assign master = slot_mask[0];

  tdm_frame_ctr #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .follow_ext  (!master),
    .fsync_in    (fsync_in),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx),
    .frame_start (frame_start)
  );

  always_comb begin
    own_now   = (bit_idx == '0) ? slot_mask[slot_idx] : own_q;
    slot_load = (bit_idx == '0) && own_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q     <= 1'b0;
      tx_done   <= 1'b0;
      fsync_out <= 1'b0;
      fsync_oe  <= 1'b0;
    end else begin
      own_q     <= own_now;
      tx_done   <= own_now && (bit_idx == LAST_BIT);
      fsync_out <= master && frame_start;
      fsync_oe  <= master;
    end
  end

  logic [SLOT_BITS-1:0] lane_par [LANES];
  logic [LANES-1:0]     lane_bit;
  logic [LANES-1:0]     lane_oe;

  assign lane_par[0] = data_word;
  assign lane_par[1] = {tx_addr, proto};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdm_lane_shifter #(.W(SLOT_BITS)) u_sh (
      .clk    (clk),
      .rst    (rst),
      .load   (slot_load),
      .active (own_now),
      .par_in (lane_par[g]),
      .bit_o  (lane_bit[g]),
      .oe_o   (lane_oe[g])
    );
  end

  assign dat_o  = lane_bit[0];
  assign dat_oe = lane_oe[0];
  assign ap_o   = lane_bit[1];
  assign ap_oe  = lane_oe[1];
endmodule

// File: rtl/tdm_mp_tx_chk.sv
module tdm_mp_tx_chk (
  input logic clk,
  input logic rst,
  input logic dat_oe,
  input logic ap_oe,
  input logic fsync_out,
  input logic fsync_oe,
  input logic tx_done
);
  // R1: registers clear on reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dat_oe && !ap_oe && !fsync_oe && !fsync_out && !tx_done));

  // R7: both lanes are released together
  a_r7_lanes_together: assert property (@(posedge clk) disable iff (rst)
    dat_oe == ap_oe);

  // R10: done only inside a driven slot
  a_r10_done_in_owned: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> dat_oe);

  // R10: done is a single-clock strobe
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  // R8: generated sync only when driving the sync pin
  a_r8_sync_driven: assert property (@(posedge clk) disable iff (rst)
    fsync_out |-> fsync_oe);

  // R8: generated sync is a one-clock pulse
  a_r8_sync_single: assert property (@(posedge clk) disable iff (rst)
    fsync_out |=> !fsync_out);
endmodule

bind tdm_mp_tx tdm_mp_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dat_oe    (dat_oe),
  .ap_oe     (ap_oe),
  .fsync_out (fsync_out),
  .fsync_oe  (fsync_oe),
  .tx_done   (tx_done)
);

// File: tb/tdm_mp_tx_bench.sv
module tdm_mp_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic dat_o, dat_oe, ap_o, ap_oe, fsync_out, fsync_oe, tx_done;

  int vectors = 0;
  int miscompares = 0;

  logic c_dat [128];
  logic c_doe [128];
  logic c_ap  [128];
  logic c_apoe[128];
  logic c_done[128];
  logic c_fso [128];
  logic c_fsoe[128];
  logic fso_next;

  always #5 clk = ~clk;

  tdm_mp_tx u_tdm_mp_tx (
    .clk(clk), .rst(rst), .fsync_in(fsync_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dat_o(dat_o), .dat_oe(dat_oe), .ap_o(ap_o), .ap_oe(ap_oe),
    .fsync_out(fsync_out), .fsync_oe(fsync_oe), .tx_done(tx_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Records 128 positions starting at slot 0 bit 0 as seen on the lanes.
  task automatic capture(input bit master_mode, input int wr_at,
                         input logic [15:0] wr_val, input int stray_at);
    if (!master_mode) begin
      @(negedge clk);
      fsync_in = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fsync_in = 1'b0;
    end else begin
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (fsync_out) break;
      end
    end
    for (int i = 0; i < 128; i++) begin
      if (i > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      c_dat[i] = dat_o;  c_doe[i] = dat_oe; c_ap[i] = ap_o; c_apoe[i] = ap_oe;
      c_done[i] = tx_done; c_fso[i] = fsync_out; c_fsoe[i] = fsync_oe;
      wr_en = 1'b0;
      if (i == wr_at) begin
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = wr_val;
      end
      fsync_in = (i == stray_at);
    end
    @(posedge clk);
    @(negedge clk);
    fso_next = fsync_out;
    fsync_in = 1'b0;
  endtask

  // Slots below sw carry d_old, slots from sw on carry d_new.
  task automatic check_frame(input string req, input logic [7:0] mask,
                             input logic [7:0] addr, input logic [7:0] proto,
                             input logic [15:0] d_old, input logic [15:0] d_new,
                             input int sw);
    for (int s = 0; s < 8; s++) begin
      logic [15:0] a_d, a_a, a_doe, a_aoe, a_done, e_d;
      for (int b = 0; b < 16; b++) begin
        a_d[15-b]   = c_dat[s*16+b];
        a_a[15-b]   = c_ap[s*16+b];
        a_doe[b]    = c_doe[s*16+b];
        a_aoe[b]    = c_apoe[s*16+b];
        a_done[b]   = c_done[s*16+b];
      end
      e_d = (s < sw) ? d_old : d_new;
      chk({req, " R7 R3"}, $sformatf("slot %0d data oe", s), a_doe, mask[s] ? 16'hFFFF : 16'h0);
      chk({req, " R7"}, $sformatf("slot %0d ap oe", s), a_aoe, mask[s] ? 16'hFFFF : 16'h0);
      chk({req, " R10"}, $sformatf("slot %0d done", s), a_done, mask[s] ? 16'h8000 : 16'h0);
      if (mask[s]) begin
        chk({req, " R4"}, $sformatf("slot %0d data word", s), a_d, e_d);
        chk({req, " R5"}, $sformatf("slot %0d addr/proto", s), a_a, {addr, proto});
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "oe during reset", {dat_oe, ap_oe, fsync_oe, fsync_out, tx_done}, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "oe after reset", {dat_oe, ap_oe, fsync_oe, fsync_out, tx_done}, 0);
    capture(1'b0, -1, 16'h0, -1);
    check_frame("R1 R7", 8'h00, 8'h0, 8'h0, 16'h0, 16'h0, 0);
  endtask

  task automatic t_single_slot();
    reg_write(2'd1, 16'h0021);
    reg_write(2'd2, 16'hAB5C);  // R6: upper byte must be dropped
    reg_write(2'd3, 16'hC3A5);
    reg_write(2'd0, 16'h0004);  // R11 select encodings
    capture(1'b0, -1, 16'h0, -1);
    check_frame("R3 R5 R6 R11", 8'h04, 8'h21, 8'h5C, 16'hC3A5, 16'hC3A5, 0);
    chk("R8", "slave leaves sync released", {c_fsoe[0], c_fso[0]}, 0);
    // R2: resync at an arbitrary point restarts the frame
    repeat (37) @(negedge clk);
    capture(1'b0, -1, 16'h0, -1);
    check_frame("R2", 8'h04, 8'h21, 8'h5C, 16'hC3A5, 16'hC3A5, 0);
  endtask

  task automatic t_multi_slot();
    reg_write(2'd1, 16'h0080);
    reg_write(2'd2, 16'h0001);
    reg_write(2'd3, 16'h8001);
    reg_write(2'd0, 16'h0052);
    capture(1'b0, -1, 16'h0, -1);
    check_frame("R3 R10", 8'h52, 8'h80, 8'h01, 16'h8001, 16'h8001, 0);
  endtask

  task automatic t_mid_write();
    reg_write(2'd3, 16'h1234);
    reg_write(2'd0, 16'h0006);
    capture(1'b0, 20, 16'hFEDC, -1);  // write lands at slot 1 bit 5
    check_frame("R9", 8'h06, 8'h80, 8'h01, 16'h1234, 16'hFEDC, 2);
  endtask

  task automatic t_master();
    reg_write(2'd3, 16'h5AA5);
    reg_write(2'd0, 16'h0081);
    capture(1'b1, -1, 16'h0, 40);
    begin
      int pulses = 0;
      for (int i = 0; i < 128; i++) pulses += int'(c_fso[i]);
      chk("R8", "sync oe", c_fsoe[0], 1'b1);
      chk("R8", "sync at slot0 bit0", c_fso[0], 1'b1);
      chk("R8", "one sync per frame", pulses, 1);
      chk("R8", "sync after 128 clocks despite stray input", fso_next, 1'b1);
    end
    check_frame("R8", 8'h81, 8'h80, 8'h01, 16'h5AA5, 16'h5AA5, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_single_slot();
    t_multi_slot();
    t_mid_write();
    t_master();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule